// File: doc/BRIEF.md
# Iterative Multiply/Divide Coprocessor with Result-Save Flag

This block is a multiply and divide helper that sits beside a 16-bit CPU and is driven entirely through a small register window. It holds one 32-bit working register, seen on the bus as a low half and a high half. A multiply takes its first factor from the low half and its second from the `opnd` input. It forms the 32-bit product with radix-2 Booth recoding, one bit per cycle. A divide takes the whole 32-bit register as dividend and `opnd` as divisor. It uses restoring division, one quotient bit per cycle, and leaves the quotient in the low half and the remainder in the high half.

A control word reports three bits: the unit is running, the working register holds live data, and a divide could not produce a valid result. The live-data bit is raised by any accepted bus write to a result half and by any accepted start. It drops only when the low half is read. An interrupt handler can therefore tell whether it must save and restore the working register before using the unit itself.

Top module: `muldiv_unit`

## Requirements
- R1: Bus address 0 selects the low result half, address 1 the high half, address 2 the control word (bit 0 busy, bit 1 in-use, bit 2 overflow, other bits zero), and address 3 reads zero. `bus_rdata` follows `bus_addr` combinationally. After reset, both halves and all control bits are zero.
- R2: `op_sel` code 0 is a signed multiply and code 1 an unsigned multiply. Either one writes the full 32-bit product of the low half and `opnd` into the result register.
- R3: `op_sel` code 2 is a signed divide and code 3 an unsigned divide of the 32-bit result register by `opnd`. The quotient goes to the low half and the remainder to the high half. A signed quotient truncates toward zero, and the remainder carries the dividend's sign.
- R4: A divisor of zero, or a quotient outside the 16-bit range of the selected mode, sets the overflow bit and leaves the result register unchanged. The overflow bit stays set until a write to the control word with bit 2 at 1 while the unit is idle.
- R5: `busy` goes high in the cycle after an accepted start. It stays high for 17 cycles for a multiply and 18 cycles for a divide. `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R6: The in-use bit becomes 1 after any accepted write to either result half and after any accepted start.
- R7: A read of the low half clears the in-use bit and a read of the high half leaves it unchanged. When a set and a clear fall in the same cycle, the bit ends up set.
- R8: A bus write to a result half or to the control word is ignored while `busy` is high, and also in the cycle in which a start is accepted.
- R9: A start request while `busy` is high is ignored: the running operation keeps its operands, its mode and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 low half, 1 high half, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on the in-use bit) |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the selected register |
| start | input | 1 | Begin an operation when idle |
| op_sel | input | 2 | Mode: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opnd | input | W | Second factor or divisor, sampled with the start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The multiply sweep crosses sign-boundary values such as 0x7FFF, 0x8000 and 0xFFFF in both modes. A Booth engine that skipped the unsigned correction would return a high half short by one factor whenever the second factor has its top bit set. The divide sweeps reach the edges of the signed quotient range, where exactly -32768 is legal and +32768 is not, as well as divide by zero and high dividend halves at or above the divisor. A unit that checked the range wrongly would either corrupt the result register or fail to flag the overflow. Directed runs write data, write the control word and issue a second start in the middle of an operation. A unit that let any of these through would return a damaged result or change its latency. The in-use bit is probed through low reads, high reads, and a start that arrives together with a low read, which catches a unit that gives the clear priority over the set.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_SMUL = 2'd0,
        OP_UMUL = 2'd1,
        OP_SDIV = 2'd2,
        OP_UDIV = 2'd3
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } md_state_e;

    typedef enum logic [1:0] {
        RA_LO   = 2'd0,
        RA_HI   = 2'd1,
        RA_CTL  = 2'd2,
        RA_NONE = 2'd3
    } md_addr_e;

    localparam int CTL_BUSY  = 0;
    localparam int CTL_INUSE = 1;
    localparam int CTL_OVF   = 2;

    function automatic logic op_is_div(md_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_signed(md_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/md_mul_engine.sv
module md_mul_engine #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           is_signed,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod_next
);
    localparam int AW = W + 2;

    logic signed [AW-1:0] acc, mc, sum, acc_n;
    logic [W-1:0]         q, q_n, hi_fix;
    logic                 qm1, corr;

    // One Booth step: add or subtract the factor, then arithmetic shift right.
    always_comb begin
        unique case ({q[0], qm1})
            2'b01:   sum = acc + mc;
            2'b10:   sum = acc - mc;
            default: sum = acc;
        endcase
        acc_n  = {sum[AW-1], sum[AW-1:1]};
        q_n    = {sum[0], q[W-1:1]};
        // Unsigned second factor with top bit set was taken as negative: add it back.
        hi_fix = acc_n[W-1:0] + (corr ? mc[W-1:0] : '0);
        prod_next = {hi_fix, q_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            mc   <= '0;
            q    <= '0;
            qm1  <= 1'b0;
            corr <= 1'b0;
        end else if (load) begin
            acc  <= '0;
            mc   <= {{2{is_signed & mcand[W-1]}}, mcand};
            q    <= mplier;
            qm1  <= 1'b0;
            corr <= ~is_signed & mplier[W-1];
        end else if (step) begin
            acc  <= acc_n;
            q    <= q_n;
            qm1  <= q[0];
        end
    end

endmodule

// File: rtl/md_div_engine.sv
module md_div_engine #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           is_signed,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem_out,
    output logic           ovf
);
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0]     r, sh, diff;
    logic [W-1:0]   qq, dv, mag_dv;
    logic [2*W-1:0] mag_dd;
    logic           neg_q, neg_r, sgn, early_ovf;
    logic           dd_neg, dv_neg, fits, range_bad;

    always_comb begin
        dd_neg = is_signed & dividend[2*W-1];
        dv_neg = is_signed & divisor[W-1];
        mag_dd = dd_neg ? -dividend : dividend;
        mag_dv = dv_neg ? -divisor : divisor;
    end

    // Restoring step: shift one dividend bit in, subtract if it fits.
    always_comb begin
        sh   = {r[W-1:0], qq[W-1]};
        fits = (sh >= {1'b0, dv});
        diff = sh - {1'b0, dv};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r         <= '0;
            qq        <= '0;
            dv        <= '0;
            neg_q     <= 1'b0;
            neg_r     <= 1'b0;
            sgn       <= 1'b0;
            early_ovf <= 1'b0;
        end else if (load) begin
            r         <= {1'b0, mag_dd[2*W-1:W]};
            qq        <= mag_dd[W-1:0];
            dv        <= mag_dv;
            neg_q     <= dd_neg ^ dv_neg;
            neg_r     <= dd_neg;
            sgn       <= is_signed;
            early_ovf <= (mag_dv == '0) || (mag_dd[2*W-1:W] >= mag_dv);
        end else if (step) begin
            r  <= fits ? diff : sh;
            qq <= {qq[W-2:0], fits};
        end
    end

    always_comb begin
        quo       = neg_q ? -qq : qq;
        rem_out   = neg_r ? -r[W-1:0] : r[W-1:0];
        range_bad = sgn && (neg_q ? (qq > NEG_LIM) : qq[W-1]);
        ovf       = early_ovf | range_bad;
    end

endmodule

// File: rtl/md_regs.sv
module md_regs
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     addr,
    input  logic           wr,
    input  logic           rd,
    input  logic [W-1:0]   wdata,
    input  logic           busy,
    input  logic           start_acc,
    input  logic           wb_en,
    input  logic [2*W-1:0] wb_data,
    input  logic           ovf_set,
    output logic [2*W-1:0] md,
    output logic           inuse,
    output logic           ovf,
    output logic [W-1:0]   rdata
);
    md_addr_e a_sel;
    logic     wr_ok, iu_set, iu_clr;

    always_comb begin
        a_sel  = md_addr_e'(addr);
        wr_ok  = wr & ~busy & ~start_acc;
        iu_set = start_acc | (wr_ok & ((a_sel == RA_LO) | (a_sel == RA_HI)));
        iu_clr = rd & (a_sel == RA_LO);
    end

    always_comb begin
        rdata = '0;
        unique case (a_sel)
            RA_LO:  rdata = md[W-1:0];
            RA_HI:  rdata = md[2*W-1:W];
            RA_CTL: begin
                rdata[CTL_BUSY]  = busy;
                rdata[CTL_INUSE] = inuse;
                rdata[CTL_OVF]   = ovf;
            end
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            md    <= '0;
            inuse <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (wb_en)
                md <= wb_data;
            else if (wr_ok && a_sel == RA_LO)
                md[W-1:0] <= wdata;
            else if (wr_ok && a_sel == RA_HI)
                md[2*W-1:W] <= wdata;

            if (iu_set)
                inuse <= 1'b1;
            else if (iu_clr)
                inuse <= 1'b0;

            if (ovf_set)
                ovf <= 1'b1;
            else if (wr_ok && a_sel == RA_CTL && wdata[CTL_OVF])
                ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         start,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd,
    output logic         busy,
    output logic         done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    md_state_e       state;
    md_op_e          op_q;
    logic [W-1:0]    opnd_q;
    logic [CW-1:0]   cnt;
    logic            start_acc, last, is_div, is_sgn;
    logic            mul_load, mul_step, div_load, div_step;
    logic            mul_wb, div_wb, ovf_set, wb_en;
    logic [2*W-1:0]  md, prod_next, wb_data;
    logic [W-1:0]    quo, rem_v;
    logic            div_ovf, inuse, ovf_flag, done_q;

    always_comb begin
        start_acc = start && (state == ST_IDLE);
        last      = (cnt == LAST_STEP);
        is_div    = op_is_div(op_q);
        is_sgn    = op_is_signed(op_q);
        mul_load  = (state == ST_SETUP) && !is_div;
        div_load  = (state == ST_SETUP) && is_div;
        mul_step  = (state == ST_ITER) && !is_div;
        div_step  = (state == ST_ITER) && is_div;
        mul_wb    = mul_step && last;
        div_wb    = (state == ST_FIX) && !div_ovf;
        ovf_set   = (state == ST_FIX) && div_ovf;
        wb_en     = mul_wb | div_wb;
        wb_data   = mul_wb ? prod_next : {rem_v, quo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_SMUL;
            opnd_q <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= mul_wb | (state == ST_FIX);
            unique case (state)
                ST_IDLE: if (start_acc) begin
                    op_q   <= md_op_e'(op_sel);
                    opnd_q <= opnd;
                    state  <= ST_SETUP;
                end
                ST_SETUP: begin
                    cnt   <= '0;
                    state <= ST_ITER;
                end
                ST_ITER: begin
                    cnt <= cnt + 1'b1;
                    if (last)
                        state <= is_div ? ST_FIX : ST_IDLE;
                end
                ST_FIX: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = done_q;

    md_mul_engine #(.W(W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .load      (mul_load),
        .step      (mul_step),
        .is_signed (is_sgn),
        .mcand     (md[W-1:0]),
        .mplier    (opnd_q),
        .prod_next (prod_next)
    );

    md_div_engine #(.W(W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (div_load),
        .step      (div_step),
        .is_signed (is_sgn),
        .dividend  (md),
        .divisor   (opnd_q),
        .quo       (quo),
        .rem_out   (rem_v),
        .ovf       (div_ovf)
    );

    md_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .busy      (busy),
        .start_acc (start_acc),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .ovf_set   (ovf_set),
        .md        (md),
        .inuse     (inuse),
        .ovf       (ovf_flag),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/md_checker.sv
module md_checker #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [1:0]     bus_addr,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic           wdata_ovf_bit,
    input logic           start,
    input logic [1:0]     op_sel,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] md,
    input logic           inuse,
    input logic           ovf
);
    logic [7:0] ck_len;
    logic       ck_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_len <= '0;
            ck_div <= 1'b0;
        end else begin
            ck_len <= busy ? ck_len + 8'd1 : 8'd0;
            if (start && !busy)
                ck_div <= op_sel[1];
        end
    end

    // R5
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);
    a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ck_len == (ck_div ? 8'd18 : 8'd17));
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6
    a_r6_inuse_on_start: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> inuse);
    a_r6_inuse_on_write: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !busy && !start && !bus_addr[1] |=> inuse);
    // R7
    a_r7_lo_read_clears: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == 2'd0 && !bus_wr && !(start && !busy) |=> !inuse);
    a_r7_hi_read_keeps: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == 2'd1 && !bus_wr && !(start && !busy) |=> inuse == $past(inuse));
    // R8
    a_r8_md_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(md) || done));
    // R4
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf && !(bus_wr && !busy && bus_addr == 2'd2 && wdata_ovf_bit) |=> ovf);
    a_r4_ovf_keeps_md: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $stable(md));

endmodule

bind muldiv_unit md_checker #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .wdata_ovf_bit (bus_wdata[2]),
    .start         (start),
    .op_sel        (op_sel),
    .busy          (busy),
    .done          (done),
    .md            (md),
    .inuse         (inuse),
    .ovf           (ovf_flag)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, start = 1'b0;
    logic [15:0] bus_wdata = '0, opnd = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  op_sel = '0;
    logic        busy, done;

    int total = 0;
    int bad = 0;
    bit ovf_exp = 1'b0;
    logic [31:0] seed = 32'h1357_9bdf;

    always #10 clk = ~clk;

    muldiv_unit #(.W(16)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start), .op_sel(op_sel),
        .opnd(opnd), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] corner(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
            6: return 16'hFFFF;  default: return 16'h00FF;
        endcase
    endfunction

    task automatic nxt(output logic [31:0] v);
        seed = seed * 32'd1664525 + 32'd1013904223;
        v = seed;
    endtask

    task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [15:0] b,
                         output logic [31:0] res, output bit ov);
        longint p, q, r;
        ov = 1'b0;
        res = a;
        case (op)
            2'd0: begin p = longint'($signed(a[15:0])) * longint'($signed(b)); res = p[31:0]; end
            2'd1: begin p = longint'({48'd0, a[15:0]}) * longint'({48'd0, b}); res = p[31:0]; end
            2'd2: begin
                if (b == 16'd0) ov = 1'b1;
                else begin
                    q = longint'($signed(a)) / longint'($signed(b));
                    r = longint'($signed(a)) % longint'($signed(b));
                    if (q > 32767 || q < -32768) ov = 1'b1;
                    else res = {r[15:0], q[15:0]};
                end
            end
            default: begin
                if (b == 16'd0) ov = 1'b1;
                else begin
                    q = longint'({32'd0, a}) / longint'({48'd0, b});
                    r = longint'({32'd0, a}) % longint'({48'd0, b});
                    if (q > 65535) ov = 1'b1;
                    else res = {r[15:0], q[15:0]};
                end
            end
        endcase
    endtask

    // Runs one operation; disturb injects a start, a result write and a control write mid-run.
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [15:0] b,
                          input bit disturb, input bit keep_ovf);
        logic [31:0] exp_res;
        bit          ov;
        logic [15:0] v;
        int          n;
        string       rq;
        rq = op[1] ? "R3" : "R2";
        model(op, a, b, exp_res, ov);
        if (ov) ovf_exp = 1'b1;
        wr(2'd0, a[15:0]);
        wr(2'd1, a[31:16]);
        op_sel = op; opnd = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk("R5 busy after start", {31'd0, busy}, 32'd1);
        while (!done && n < 40) begin
            if (disturb && n == 4) begin start = 1'b1; op_sel = ~op; opnd = ~b; end
            if (disturb && n == 5) begin start = 1'b0; bus_addr = 2'd0; bus_wdata = 16'hDEAD; bus_wr = 1'b1; end
            if (disturb && n == 6) begin bus_addr = 2'd2; bus_wdata = 16'h0004; end
            if (disturb && n == 7) bus_wr = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0; bus_wr = 1'b0;
        chk(disturb ? "R9 latency" : "R5 latency", n, op[1] ? 32'd19 : 32'd18);
        rd(2'd2, v);
        chk(op[1] ? "R4 ctl after div" : "R6 ctl after mul", {16'd0, v}, {29'd0, ovf_exp, 2'b10});
        chk("R5 done one cycle", {31'd0, done}, 32'd0);
        rd(2'd1, v);
        chk(ov ? "R4 hi unchanged" : (disturb ? "R8 hi" : rq), {16'd0, v}, {16'd0, exp_res[31:16]});
        rd(2'd0, v);
        chk(ov ? "R4 lo unchanged" : (disturb ? "R8 lo" : rq), {16'd0, v}, {16'd0, exp_res[15:0]});
        if (ovf_exp && !keep_ovf) begin
            wr(2'd2, 16'h0004);
            ovf_exp = 1'b0;
            rd(2'd2, v);
            chk("R4 ovf cleared", {16'd0, v}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] r1, r2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 reset lo", {16'd0, v}, 32'd0);
        rd(2'd1, v); chk("R1 reset hi", {16'd0, v}, 32'd0);
        rd(2'd2, v); chk("R1 reset ctl", {16'd0, v}, 32'd0);
        chk("R1 reset busy/done", {30'd0, busy, done}, 32'd0);

        // R1 / R6 / R7 flag rules
        wr(2'd0, 16'hA5A5);
        rd(2'd2, v); chk("R6 inuse after lo write", {16'd0, v}, 32'd2);
        wr(2'd1, 16'h5A5A);
        rd(2'd1, v); chk("R1 hi readback", {16'd0, v}, 32'h5A5A);
        rd(2'd2, v); chk("R7 hi read keeps inuse", {16'd0, v}, 32'd2);
        rd(2'd0, v); chk("R1 lo readback", {16'd0, v}, 32'hA5A5);
        rd(2'd2, v); chk("R7 lo read clears inuse", {16'd0, v}, 32'd0);
        rd(2'd3, v); chk("R1 addr3 zero", {16'd0, v}, 32'd0);
        wr(2'd1, 16'h0001);
        rd(2'd2, v); chk("R6 inuse after hi write", {16'd0, v}, 32'd2);
        rd(2'd0, v);
        rd(2'd2, v); chk("R7 cleared again", {16'd0, v}, 32'd0);

        // R8: write in the start cycle is dropped; R7: start beats a same-cycle low read
        wr(2'd0, 16'd5); wr(2'd1, 16'd0); rd(2'd0, v);
        op_sel = 2'd1; opnd = 16'd7; start = 1'b1;
        bus_addr = 2'd0; bus_wdata = 16'd3; bus_wr = 1'b1;
        @(negedge clk);
        start = 1'b0; bus_wr = 1'b0;
        while (!done) @(negedge clk);
        rd(2'd0, v); chk("R8 write at start ignored", {16'd0, v}, 32'd35);
        op_sel = 2'd1; opnd = 16'd2; start = 1'b1; bus_addr = 2'd0; bus_rd = 1'b1;
        @(negedge clk);
        start = 1'b0; bus_rd = 1'b0;
        while (!done) @(negedge clk);
        rd(2'd2, v); chk("R7 set wins over clear", {16'd0, v}, 32'd2);
        rd(2'd0, v);

        // R4 sticky overflow across a later good op, and control write while busy ignored (R8)
        run_op(2'd3, 32'h0001_0000, 16'h0000, 1'b0, 1'b1);
        run_op(2'd1, 32'h0000_1234, 16'h0010, 1'b1, 1'b0);
        // R9 / R8 disturbances on other modes
        run_op(2'd2, 32'hFFFF_8000, 16'h0007, 1'b1, 1'b0);
        run_op(2'd0, 32'h0000_8001, 16'h7FFF, 1'b1, 1'b0);

        // R2 multiply sweep over corners, both modes
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(2'(m), {16'd0, corner(i)}, corner(j), 1'b0, 1'b0);

        // R3 / R4 divide sweep over corner dividends and divisors
        for (int m = 2; m < 4; m++)
            for (int h = 0; h < 8; h++)
                for (int l = 0; l < 8; l += 2)
                    for (int j = 0; j < 8; j++)
                        run_op(2'(m), {corner(h), corner(l)}, corner(j), 1'b0, 1'b0);

        // Signed quotient range edges
        run_op(2'd2, 32'hFFFF_8000, 16'h0001, 1'b0, 1'b0);
        run_op(2'd2, 32'h0000_8000, 16'h0001, 1'b0, 1'b0);
        run_op(2'd2, 32'h0000_8000, 16'hFFFF, 1'b0, 1'b0);
        run_op(2'd2, 32'h8000_0000, 16'h8000, 1'b0, 1'b0);
        run_op(2'd2, 32'hC000_0000, 16'h8000, 1'b0, 1'b0);

        // Pseudo-random mix
        for (int k = 0; k < 400; k++) begin
            nxt(r1); nxt(r2);
            if (k[0])
                run_op(r1[1:0], {((r2[15:0] == 0) ? r1[31:16] : (r1[31:16] % r2[15:0])), r2[31:16]},
                       r2[15:0], 1'b0, 1'b0);
            else
                run_op(r1[1:0], {r1[31:16], r2[31:16]}, r2[15:0], 1'b0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule